// File: doc/BRIEF.md
# Privileged-Mode Entry, Return and Shadow Bank Controller

This block steers a core into and out of a privileged firmware mode. Each event arrives as a cause code and the PC it refers to. The block answers with the new fetch PC and the PC after it. It also keeps the restart address that a later return jumps back to. Events come in on a valid/ready stream and leave on a second one. The result register is one entry deep. A new event is accepted only when the output register is empty, or when the consumer takes its contents in the same cycle. When the consumer holds `out_ready` low, `ev_ready` falls and the pending result stays frozen.

The block also holds the integer register storage for a sparse group of registers that own a second, shadow copy. Entering the mode from normal operation selects the shadow bank. A return whose restart address has bit 0 clear selects the normal bank again. Only the bank select changes on a switch, so switching costs no copy cycles. Any bank switch that would select the bank already in use is refused and reported. A separate command input lets firmware select a bank directly.

Top module: `pm_shadow_ctrl`

## Requirements
- R1: Only registers 8, 9, 10, 11, 12, 13, 14 and 25 have a shadow copy. For these, `shadow_sel` picks which copy a write updates and a read returns. Every other register is a single storage shared by both banks. A read is combinational on `rf_raddr`. A write takes effect at the clock edge where `rf_we` is sampled high.
- R2: During and after reset, `priv_mode` = 1, `shadow_sel` = 1 and `restart_addr` = 0. `out_valid` = 1 with `out_pc` = BASE + 0x0001 and `out_npc` = `out_pc` + 4.
- R3: `ev_cause` codes are: 0 return, 1 interrupt, 2 firmware call, 3 machine check, 4 alignment fault, 5 to 7 unimplemented-opcode fault. Every event other than a legal return sets `out_pc` = BASE + offset. The offsets are interrupt 0x0101, firmware call 0x2001, machine check 0x0401, alignment 0x0301 and unimplemented opcode 0x0481. In all cases `out_npc` = `out_pc` + 4.
- R4: A fault (causes 3 to 7) sets `restart_addr` to `ev_pc`. An interrupt does the same when `priv_mode` is 0. An interrupt taken while `priv_mode` is 1 leaves `restart_addr` unchanged.
- R5: A firmware call sets `restart_addr` to `ev_pc` + 4, in either mode.
- R6: Every entry sets `priv_mode`. An entry with `priv_mode` = 0 requests the shadow bank. An entry with `priv_mode` = 1 requests no bank change.
- R7: A return with `priv_mode` = 1 gives `out_pc` = `restart_addr`. When bit 0 of `restart_addr` is 0, the return clears `priv_mode` and requests the normal bank. When bit 0 is 1, mode and bank stay as they are.
- R8: A return with `priv_mode` = 0 is treated as an unimplemented-opcode fault. It uses offset 0x0481, sets `restart_addr` to `ev_pc`, and enters the mode.
- R9: `irq_recheck` is high for exactly the one cycle after a legal return is accepted, and is low at all other times.
- R10: A bank request that targets the bank already selected is refused: `shadow_sel` keeps its value and `swap_err` is high for the next cycle. Requests come from an event or from `bank_cmd_valid`, with `bank_cmd_shadow` = 1 meaning the shadow bank. When both arrive in the same cycle, the event's request wins and the command is dropped.
- R11: An event is accepted when `ev_valid` && `ev_ready`, where `ev_ready` = !`out_valid` || `out_ready`. Results appear the cycle after acceptance. While `out_valid` && !`out_ready`, `out_pc` and `out_npc` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_cause | input | 3 | Event cause code |
| ev_pc | input | AW | PC of the event |
| out_valid | output | 1 | New PC result present |
| out_ready | input | 1 | Consumer takes the result |
| out_pc | output | AW | New fetch PC |
| out_npc | output | AW | Fetch PC plus 4 |
| restart_addr | output | AW | Current restart address |
| priv_mode | output | 1 | Privileged mode active |
| shadow_sel | output | 1 | Shadow bank selected |
| bank_cmd_valid | input | 1 | Direct bank selection request |
| bank_cmd_shadow | input | 1 | Requested bank, 1 = shadow |
| swap_err | output | 1 | Refused bank request, one-cycle pulse |
| irq_recheck | output | 1 | Re-evaluate pending interrupts, one-cycle pulse |
| rf_we | input | 1 | Register write enable |
| rf_waddr | input | 5 | Register write index |
| rf_wdata | input | DW | Register write data |
| rf_raddr | input | 5 | Register read index |
| rf_rdata | output | DW | Register read data |

## Verification
Every cause is sent both from normal mode and from privileged mode. This separates restart updates that depend on the mode from those that do not, and entries that switch banks from entries that do not. Returns are sent with restart addresses of both bit-0 values and from normal mode. This separates leaving the mode, staying in it, and the illegal-return fault. The full register file is written in each bank and read back across switches, which shows that only the redirected set diverges. Refused bank requests are provoked from both the command input and from events. A stalled consumer checks that results are held.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam logic [2:0] C_RETURN = 3'd0;
  localparam logic [2:0] C_INTR   = 3'd1;
  localparam logic [2:0] C_FWCALL = 3'd2;
  localparam logic [2:0] C_MCHK   = 3'd3;
  localparam logic [2:0] C_ALIGN  = 3'd4;

  localparam int VOFS_W = 16;
  localparam logic [VOFS_W-1:0] VEC_RESET  = 16'h0001;
  localparam logic [VOFS_W-1:0] VEC_INTR   = 16'h0101;
  localparam logic [VOFS_W-1:0] VEC_FWCALL = 16'h2001;
  localparam logic [VOFS_W-1:0] VEC_MCHK   = 16'h0401;
  localparam logic [VOFS_W-1:0] VEC_ALIGN  = 16'h0301;
  localparam logic [VOFS_W-1:0] VEC_UNIMPL = 16'h0481;

  // registers 8..14 and 25 carry a shadow copy
  localparam logic [31:0] REDIR_DEFAULT = 32'h0200_7F00;

  function automatic logic [VOFS_W-1:0] vec_of(input logic [2:0] cause);
    case (cause)
      C_INTR:   return VEC_INTR;
      C_FWCALL: return VEC_FWCALL;
      C_MCHK:   return VEC_MCHK;
      C_ALIGN:  return VEC_ALIGN;
      default:  return VEC_UNIMPL;
    endcase
  endfunction
endpackage

// File: rtl/pm_regbank.sv
module pm_regbank #(
  parameter int DW = 64,
  parameter int NREG = 32,
  parameter logic [NREG-1:0] REDIR = pm_pkg::REDIR_DEFAULT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    use_shadow,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DW-1:0]           wdata,
  input  logic [$clog2(NREG)-1:0] raddr,
  output logic [DW-1:0]           rdata
);
  localparam int AIW = $clog2(NREG);

  logic [DW-1:0] view [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          hit;
    logic [DW-1:0] main_q;
    assign hit = we && (waddr == AIW'(i));

    if (REDIR[i]) begin : g_dual
      logic [DW-1:0] alt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          main_q <= '0;
          alt_q  <= '0;
        end else if (hit) begin
          if (use_shadow) alt_q <= wdata;
          else            main_q <= wdata;
        end
      end
      assign view[i] = use_shadow ? alt_q : main_q;
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)   main_q <= '0;
        else if (hit) main_q <= wdata;
      end
      assign view[i] = main_q;
    end
  end

  assign rdata = view[raddr];
endmodule

// File: rtl/pm_bankctl.sv
module pm_bankctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_req,
  input  logic sw_to_shadow,
  input  logic cmd_valid,
  input  logic cmd_shadow,
  output logic shadow_sel,
  output logic swap_err
);
  logic req, tgt;
  logic shadow_q, err_q;

  always_comb begin
    if (sw_req) begin
      req = 1'b1;
      tgt = sw_to_shadow;
    end else begin
      req = cmd_valid;
      tgt = cmd_shadow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      err_q <= req && (tgt == shadow_q);
      if (req && (tgt != shadow_q)) shadow_q <= tgt;
    end
  end

  assign shadow_sel = shadow_q;
  assign swap_err   = err_q;

  AST_REFUSED_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    swap_err |-> (shadow_sel == $past(shadow_sel))); // R10
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && cmd_valid && (sw_to_shadow != shadow_q)) |=> (shadow_sel == $past(sw_to_shadow))); // R10
endmodule

// File: rtl/pm_seq.sv
module pm_seq #(
  parameter int AW = 64,
  parameter logic [AW-1:0] BASE = 64'h1_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic [2:0]    ev_cause,
  input  logic [AW-1:0] ev_pc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_pc,
  output logic [AW-1:0] out_npc,
  output logic [AW-1:0] restart_addr,
  output logic          priv_mode,
  output logic          sw_req,
  output logic          sw_to_shadow,
  output logic          recheck
);
  import pm_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [AW-1:0] PC_RESET = BASE + AW'(VEC_RESET);

  logic          ov_q, priv_q, recheck_q;
  logic [AW-1:0] pc_q, npc_q, restart_q;
  logic          accept, legal_ret, is_ret;
  logic [AW-1:0] n_pc, n_restart;
  logic          n_priv, n_swreq, n_toshadow;

  assign ev_ready = !ov_q || out_ready;
  assign accept   = ev_valid && ev_ready;
  assign is_ret   = (ev_cause == C_RETURN);
  assign legal_ret = is_ret && priv_q;

  always_comb begin
    if (legal_ret) begin
      n_pc       = restart_q;
      n_restart  = restart_q;
      n_priv     = restart_q[0];
      n_swreq    = !restart_q[0];
      n_toshadow = 1'b0;
    end else begin
      n_pc       = BASE + AW'(vec_of(ev_cause));
      if (ev_cause == C_INTR && priv_q) n_restart = restart_q;
      else if (ev_cause == C_FWCALL)    n_restart = ev_pc + STEP;
      else                              n_restart = ev_pc;
      n_priv     = 1'b1;
      n_swreq    = !priv_q;
      n_toshadow = 1'b1;
    end
  end

  assign sw_req       = accept && n_swreq;
  assign sw_to_shadow = n_toshadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q      <= 1'b1;
      pc_q      <= PC_RESET;
      npc_q     <= PC_RESET + STEP;
      restart_q <= '0;
      priv_q    <= 1'b1;
      recheck_q <= 1'b0;
    end else begin
      recheck_q <= accept && legal_ret;
      if (accept) begin
        ov_q      <= 1'b1;
        pc_q      <= n_pc;
        npc_q     <= n_pc + STEP;
        restart_q <= n_restart;
        priv_q    <= n_priv;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign out_valid    = ov_q;
  assign out_pc       = pc_q;
  assign out_npc      = npc_q;
  assign restart_addr = restart_q;
  assign priv_mode    = priv_q;
  assign recheck      = recheck_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pc) && $stable(out_npc))); // R11
  AST_ENTRY_SETS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_ret) |=> priv_mode); // R6
  AST_RECHECK_FROM_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    recheck |-> $past(priv_mode)); // R9
  AST_NESTED_INTR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ev_cause == C_INTR && priv_mode) |=> $stable(restart_addr)); // R4
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && legal_ret) |=> (out_pc == $past(restart_addr))); // R7
endmodule

// File: rtl/pm_shadow_ctrl.sv
module pm_shadow_ctrl #(
  parameter int AW = 64,
  parameter int DW = 64,
  parameter int NREG = 32,
  parameter logic [NREG-1:0] REDIR = pm_pkg::REDIR_DEFAULT,
  parameter logic [AW-1:0] BASE = 64'h1_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_valid,
  output logic                    ev_ready,
  input  logic [2:0]              ev_cause,
  input  logic [AW-1:0]           ev_pc,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [AW-1:0]           out_pc,
  output logic [AW-1:0]           out_npc,
  output logic [AW-1:0]           restart_addr,
  output logic                    priv_mode,
  output logic                    shadow_sel,
  input  logic                    bank_cmd_valid,
  input  logic                    bank_cmd_shadow,
  output logic                    swap_err,
  output logic                    irq_recheck,
  input  logic                    rf_we,
  input  logic [$clog2(NREG)-1:0] rf_waddr,
  input  logic [DW-1:0]           rf_wdata,
  input  logic [$clog2(NREG)-1:0] rf_raddr,
  output logic [DW-1:0]           rf_rdata
);
  logic sw_req, sw_to_shadow;

  pm_seq #(.AW(AW), .BASE(BASE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_cause(ev_cause), .ev_pc(ev_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc), .out_npc(out_npc),
    .restart_addr(restart_addr), .priv_mode(priv_mode),
    .sw_req(sw_req), .sw_to_shadow(sw_to_shadow), .recheck(irq_recheck)
  );

  pm_bankctl u_bank (
    .clk(clk), .rst_n(rst_n),
    .sw_req(sw_req), .sw_to_shadow(sw_to_shadow),
    .cmd_valid(bank_cmd_valid), .cmd_shadow(bank_cmd_shadow),
    .shadow_sel(shadow_sel), .swap_err(swap_err)
  );

  pm_regbank #(.DW(DW), .NREG(NREG), .REDIR(REDIR)) u_rf (
    .clk(clk), .rst_n(rst_n), .use_shadow(shadow_sel),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(rf_raddr), .rdata(rf_rdata)
  );

  AST_ENTRY_ON_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(priv_mode) |-> shadow_sel); // R6
  AST_LEAVE_NEEDS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(priv_mode) |-> irq_recheck); // R7
endmodule

// File: tb/test_pm_shadow_ctrl.sv
module test_pm_shadow_ctrl;
  localparam int AW = 64;
  localparam int DW = 64;
  localparam logic [AW-1:0] BASE = 64'h1_0000;
  localparam logic [2:0] K_RET = 3'd0, K_INTR = 3'd1, K_FW = 3'd2, K_MCHK = 3'd3, K_ALIGN = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_ready;
  logic [2:0] ev_cause = '0;
  logic [AW-1:0] ev_pc = '0;
  logic out_valid, out_ready = 1'b1;
  logic [AW-1:0] out_pc, out_npc, restart_addr;
  logic priv_mode, shadow_sel, swap_err, irq_recheck;
  logic bank_cmd_valid = 1'b0, bank_cmd_shadow = 1'b0;
  logic rf_we = 1'b0;
  logic [4:0] rf_waddr = '0, rf_raddr = '0;
  logic [DW-1:0] rf_wdata = '0, rf_rdata;

  always #10 clk = ~clk;

  pm_shadow_ctrl #(.AW(AW), .DW(DW), .BASE(BASE)) i_pm_shadow_ctrl (.*);

  typedef struct packed {
    logic [AW-1:0] pc;
    logic [AW-1:0] npc;
    logic [AW-1:0] rst;
    logic          priv;
    logic          sh;
  } exp_t;

  exp_t  sb_q [$];
  string tag_q [$];
  int checks = 0, errors = 0;
  logic m_priv = 1'b1, m_sh = 1'b1;
  logic [AW-1:0] m_restart = '0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_ref(logic [2:0] c);
    case (c)
      K_INTR:  return 16'h0101;
      K_FW:    return 16'h2001;
      K_MCHK:  return 16'h0401;
      K_ALIGN: return 16'h0301;
      default: return 16'h0481;
    endcase
  endfunction

  function automatic bit is_redir(int i);
    return (i >= 8 && i <= 14) || i == 25;
  endfunction

  // monitor: compares each result as it is handed over
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) begin
        chk("R11", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "out_pc", out_pc, e.pc);
        chk("R3", "out_npc", out_npc, e.npc);
        chk(t, "restart_addr", restart_addr, e.rst);
        chk("R6", "priv_mode", priv_mode, e.priv);
        chk("R6", "shadow_sel", shadow_sel, e.sh);
      end
    end
  end

  task automatic push_exp(logic [AW-1:0] pc, string t);
    exp_t e;
    e.pc = pc; e.npc = pc + 4; e.rst = m_restart; e.priv = m_priv; e.sh = m_sh;
    sb_q.push_back(e);
    tag_q.push_back(t);
  endtask

  // driver: predicts the result, then offers the event
  task automatic send(logic [2:0] c, logic [AW-1:0] pc, string t);
    logic [AW-1:0] epc;
    logic e_err, e_rc;
    e_err = 1'b0; e_rc = 1'b0;
    if (c == K_RET && m_priv) begin
      epc = m_restart; e_rc = 1'b1;
      if (!m_restart[0]) begin
        e_err = (m_sh == 1'b0);
        m_sh = 1'b0; m_priv = 1'b0;
      end
    end else begin
      epc = BASE + AW'(vec_ref(c));
      if (!(c == K_INTR && m_priv)) m_restart = (c == K_FW) ? pc + 4 : pc;
      if (!m_priv) begin
        e_err = m_sh; m_sh = 1'b1;
      end
      m_priv = 1'b1;
    end
    push_exp(epc, t);
    @(negedge clk);
    ev_valid = 1'b1; ev_cause = c; ev_pc = pc;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R10", "swap_err after event", swap_err, e_err);
    chk("R9", "irq_recheck after event", irq_recheck, e_rc);
  endtask

  task automatic bank_cmd(logic v);
    logic e_err;
    e_err = (v == m_sh);
    m_sh = v;
    @(negedge clk);
    bank_cmd_valid = 1'b1; bank_cmd_shadow = v;
    @(negedge clk);
    bank_cmd_valid = 1'b0;
    chk("R10", "swap_err after command", swap_err, e_err);
    chk("R10", "shadow_sel after command", shadow_sel, m_sh);
  endtask

  task automatic wr(int i, logic [DW-1:0] d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 5'(i); rf_wdata = d;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  task automatic rd(int i, logic [DW-1:0] exp);
    @(negedge clk);
    rf_raddr = 5'(i);
    #1;
    chk("R1", $sformatf("reg %0d", i), rf_rdata, exp);
  endtask

  task automatic set_ordy(logic v);
    @(posedge clk);
    #1 out_ready = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    push_exp(BASE + 64'h1, "R2");
    repeat (3) @(posedge clk);
    chk("R2", "priv in reset", priv_mode, 1);
    chk("R2", "shadow in reset", shadow_sel, 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "out_valid after reset", out_valid, 1);
    chk("R2", "swap_err after reset", swap_err, 0);
    chk("R9", "irq_recheck after reset", irq_recheck, 0);

    // R1: fill both banks and compare
    for (int i = 0; i < 32; i++) wr(i, 64'hA00 + i);
    send(K_RET, 64'h0, "R7");
    for (int i = 0; i < 32; i++) wr(i, 64'hB00 + i);
    for (int i = 0; i < 32; i++) rd(i, 64'hB00 + i);
    send(K_MCHK, 64'h1000, "R4");
    for (int i = 0; i < 32; i++) rd(i, is_redir(i) ? 64'hA00 + i : 64'hB00 + i);
    wr(3, 64'hC03);

    send(K_ALIGN, 64'h1100, "R4");
    send(K_INTR, 64'h1200, "R4");
    send(K_FW, 64'h2000, "R5");
    send(K_RET, 64'h0, "R7");
    rd(3, 64'hC03);
    rd(9, 64'hB09);
    send(K_INTR, 64'h3000, "R4");
    send(K_RET, 64'h0, "R7");
    send(K_FW, 64'h4001, "R5");
    send(K_RET, 64'h0, "R7");
    send(K_RET, 64'h0, "R7");
    send(K_MCHK, 64'h5000, "R4");
    send(K_RET, 64'h0, "R7");
    send(K_RET, 64'h6000, "R8");

    // R10: refused and accepted bank requests
    bank_cmd(1'b1);
    bank_cmd(1'b0);
    send(K_RET, 64'h0, "R7");
    bank_cmd(1'b1);
    send(K_INTR, 64'h7000, "R4");
    rd(9, 64'hA09);
    rd(7, 64'hB07);
    send(K_RET, 64'h0, "R7");
    rd(9, 64'hB09);

    // R11: stalled consumer
    repeat (3) @(negedge clk);
    set_ordy(1'b0);
    send(3'd6, 64'h8000, "R8");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11", "ev_ready while stalled", ev_ready, 0);
      chk("R11", "out_pc held", out_pc, BASE + 64'h481);
      chk("R11", "out_valid held", out_valid, 1);
    end
    set_ordy(1'b1);
    repeat (5) @(negedge clk);
    chk("R11", "all results delivered", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule